// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Decoder

This block sits on a host-side I/O request bus and provides indirect access to PCI configuration space through two I/O ports. The host first stores a configuration address in the address port (I/O byte address 0xCF8). A later access to the data port (byte addresses 0xCFC to 0xCFF) then becomes a configuration read or write on a downstream request/response channel. That request carries the bus, device, function, dword register index and byte enables. Any host access that does not qualify is sent on a separate plain I/O channel without change.

The host interface works on dword addresses: `hst_addr` carries byte-address bits 15:2, so the address port is dword 0x33E and the data port is dword 0x33F. A byte or word access inside the data window is expressed through `hst_be`. The host raises `hst_req` with the access fields and holds them until `hst_done` pulses. It then drops `hst_req` in that same cycle. Only one access is outstanding at a time.

The control machine has four states: IDLE, CFG_WAIT, IO_WAIT and DONE. In IDLE, an accepted access goes to one of three places. A full-dword address-port access goes straight to DONE, and a write also loads the latch. An enabled data-port access goes to CFG_WAIT. Anything else goes to IO_WAIT. CFG_WAIT moves to DONE when `cfg_rsp_valid` arrives, and IO_WAIT moves to DONE when `pio_done` arrives. DONE always returns to IDLE.

Top module: `cfgdec_top`

## Requirements
- R1: After reset, `hst_done`, `cfg_req` and `pio_req` are low, and a full-dword read of the address port returns 0.
- R2: A full-dword write (`hst_be`=4'hF) to the address port stores bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register index). A full-dword read returns the stored value with bits 30:24 and 1:0 read as zero.
- R3: An address-port access with any `hst_be` other than 4'hF leaves the stored address unchanged. It is issued on the plain I/O channel, and a read returns `pio_rdata`.
- R4: A data-port access while the enable bit is 1 raises `cfg_req`. The request carries `cfg_bus`, `cfg_dev`, `cfg_fn` and `cfg_idx` taken from the stored address fields listed in R2.
- R5: A configuration request carries `hst_we` as `cfg_we`, `hst_be` as `cfg_be` and `hst_wdata` as `cfg_wdata`.
- R6: A data-port access while the enable bit is 0 raises no `cfg_req`. It is issued on the plain I/O channel instead.
- R7: During a configuration access, `hst_done` stays low until `cfg_rsp_valid` arrives. If `cfg_rsp_hit` is 1, a read returns `cfg_rsp_data`.
- R8: A configuration read that completes with `cfg_rsp_hit`=0 returns 32'hFFFF_FFFF.
- R9: An access to any other address is issued on the plain I/O channel with unchanged address, write flag, byte enables and write data. A read returns `pio_rdata`.
- R10: A full-dword address-port access completes with `hst_done` in the cycle after acceptance. It raises no downstream request.
- R11: `hst_done` is high for exactly one cycle per access. `cfg_req` and `pio_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request, held until done |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | IO_AW | Host dword I/O address (byte bits 15:2) |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with hst_done |
| cfg_req | output | 1 | Configuration request, held until response |
| cfg_we | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_idx | output | 6 | Target dword register index |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Configuration response strobe |
| cfg_rsp_hit | input | 1 | A device claimed the access |
| cfg_rsp_data | input | 32 | Configuration read data |
| pio_req | output | 1 | Plain I/O request, held until done |
| pio_we | output | 1 | Plain I/O write |
| pio_addr | output | IO_AW | Plain I/O dword address |
| pio_be | output | 4 | Plain I/O byte enables |
| pio_wdata | output | 32 | Plain I/O write data |
| pio_done | input | 1 | Plain I/O completion strobe |
| pio_rdata | input | 32 | Plain I/O read data |

## Verification
Each result has a fixed due time, counted from the clock edge that accepts a request:

- An address-port access completes on that edge, so `hst_done` is high at the next sample and the stored address takes the new value.
- For a forwarded access, `cfg_req` or `pio_req` is high at the next sample.
- `hst_done` appears one edge after the cycle in which the responder strobes.

The bench drives and samples on falling edges. It sets the response delay for each access and checks the outputs on every sample. This confirms the stall, the single-cycle completion and the return to idle, each at its exact cycle.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {ACC_ADDR, ACC_CFG, ACC_IO} acc_kind_e;

    typedef enum logic [1:0] {ST_IDLE, ST_CFG_WAIT, ST_IO_WAIT, ST_DONE} ctl_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] idx;
    } cfg_addr_t;
endpackage

// File: rtl/cfgdec_decode.sv
module cfgdec_decode
    import cfgdec_pkg::*;
#(
    parameter int               IO_AW     = 14,
    parameter logic [IO_AW-1:0] ADDR_PORT = 14'h33E,
    parameter logic [IO_AW-1:0] DATA_PORT = 14'h33F
) (
    input  logic [IO_AW-1:0] addr,
    input  logic [BE_W-1:0]  be,
    input  logic             cfg_en,
    output acc_kind_e        kind
);
    localparam logic [BE_W-1:0] FULL_BE = '1;

    always_comb begin
        if (addr == ADDR_PORT && be == FULL_BE)
            kind = ACC_ADDR;
        else if (addr == DATA_PORT && cfg_en)
            kind = ACC_CFG;
        else
            kind = ACC_IO;
    end
endmodule

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_en_bit,
    input  logic [23:2]       wr_fields,
    output cfg_addr_t         q,
    output logic [DATA_W-1:0] view
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= '{en: wr_en_bit, bus: wr_fields[23:16], dev: wr_fields[15:11],
                   fn: wr_fields[10:8], idx: wr_fields[7:2]};
    end

    assign view = {q.en, 7'b0, q.bus, q.dev, q.fn, q.idx, 2'b00};

    p_hold_unless_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
endmodule

// File: rtl/cfgdec_ctrl.sv
module cfgdec_ctrl
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] addr_view,
    input  logic              cfg_rsp_valid,
    input  logic              cfg_rsp_hit,
    input  logic [DATA_W-1:0] cfg_rsp_data,
    input  logic              pio_done,
    input  logic [DATA_W-1:0] pio_rdata,
    output logic              addr_wr,
    output logic              hst_done,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              cfg_req,
    output logic              pio_req
);
    ctl_state_e        st_q, st_d;
    logic [DATA_W-1:0] rd_q;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && hst_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        addr_wr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (hst_req) begin
                    unique case (kind)
                        ACC_ADDR: begin
                            st_d    = ST_DONE;
                            addr_wr = hst_we;
                        end
                        ACC_CFG: st_d = ST_CFG_WAIT;
                        default: st_d = ST_IO_WAIT;
                    endcase
                end
            end
            ST_CFG_WAIT: if (cfg_rsp_valid) st_d = ST_DONE;
            ST_IO_WAIT:  if (pio_done)      st_d = ST_DONE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hst_done = (st_q == ST_DONE);
        cfg_req  = (st_q == ST_CFG_WAIT);
        pio_req  = (st_q == ST_IO_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (accept && kind == ACC_ADDR)
            rd_q <= addr_view;
        else if (st_q == ST_CFG_WAIT && cfg_rsp_valid)
            rd_q <= cfg_rsp_hit ? cfg_rsp_data : '1;
        else if (st_q == ST_IO_WAIT && pio_done)
            rd_q <= pio_rdata;
    end

    assign hst_rdata = rd_q;

    p_addr_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind == ACC_ADDR |=> hst_done && !cfg_req && !pio_req);

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_rsp_valid |=> cfg_req && !hst_done);

    p_miss_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_rsp_valid && !cfg_rsp_hit |=> hst_done && hst_rdata == '1);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done);
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter int               IO_AW     = 14,
    parameter logic [IO_AW-1:0] ADDR_PORT = 14'h33E,
    parameter logic [IO_AW-1:0] DATA_PORT = 14'h33F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [IO_AW-1:0]  hst_addr,
    input  logic [3:0]        hst_be,
    input  logic [31:0]       hst_wdata,
    output logic              hst_done,
    output logic [31:0]       hst_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [7:0]        cfg_bus,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [5:0]        cfg_idx,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_rsp_valid,
    input  logic              cfg_rsp_hit,
    input  logic [31:0]       cfg_rsp_data,
    output logic              pio_req,
    output logic              pio_we,
    output logic [IO_AW-1:0]  pio_addr,
    output logic [3:0]        pio_be,
    output logic [31:0]       pio_wdata,
    input  logic              pio_done,
    input  logic [31:0]       pio_rdata
);
    cfg_addr_t         ca_q;
    logic [DATA_W-1:0] ca_view;
    acc_kind_e         kind;
    logic              addr_wr;

    cfgdec_decode #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_decode (
        .addr   (hst_addr),
        .be     (hst_be),
        .cfg_en (ca_q.en),
        .kind   (kind)
    );

    cfgdec_addr_reg u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (addr_wr),
        .wr_en_bit (hst_wdata[31]),
        .wr_fields (hst_wdata[23:2]),
        .q         (ca_q),
        .view      (ca_view)
    );

    cfgdec_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .hst_req       (hst_req),
        .hst_we        (hst_we),
        .kind          (kind),
        .addr_view     (ca_view),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_hit   (cfg_rsp_hit),
        .cfg_rsp_data  (cfg_rsp_data),
        .pio_done      (pio_done),
        .pio_rdata     (pio_rdata),
        .addr_wr       (addr_wr),
        .hst_done      (hst_done),
        .hst_rdata     (hst_rdata),
        .cfg_req       (cfg_req),
        .pio_req       (pio_req)
    );

    assign cfg_we    = hst_we;
    assign cfg_bus   = ca_q.bus;
    assign cfg_dev   = ca_q.dev;
    assign cfg_fn    = ca_q.fn;
    assign cfg_idx   = ca_q.idx;
    assign cfg_be    = hst_be;
    assign cfg_wdata = hst_wdata;

    assign pio_we    = hst_we;
    assign pio_addr  = hst_addr;
    assign pio_be    = hst_be;
    assign pio_wdata = hst_wdata;

    p_only_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> $past(ca_q.en));

    p_target_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_rsp_valid |=> $stable({cfg_bus, cfg_dev, cfg_fn, cfg_idx}));

    p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && pio_req));
endmodule

// File: tb/cfgdec_top_tb.sv
module cfgdec_top_tb;
    localparam int CLK_P = 10;
    localparam logic [13:0] A_PORT = 14'h33E;
    localparam logic [13:0] D_PORT = 14'h33F;
    localparam logic [31:0] KEEP   = 32'h80FF_FFFC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hst_req = 0, hst_we = 0;
    logic [13:0] hst_addr = '0;
    logic [3:0]  hst_be = '0;
    logic [31:0] hst_wdata = '0;
    logic hst_done; logic [31:0] hst_rdata;
    logic cfg_req, cfg_we; logic [7:0] cfg_bus; logic [4:0] cfg_dev;
    logic [2:0] cfg_fn; logic [5:0] cfg_idx; logic [3:0] cfg_be; logic [31:0] cfg_wdata;
    logic cfg_rsp_valid = 0, cfg_rsp_hit = 0; logic [31:0] cfg_rsp_data = '0;
    logic pio_req, pio_we; logic [13:0] pio_addr; logic [3:0] pio_be; logic [31:0] pio_wdata;
    logic pio_done = 0; logic [31:0] pio_rdata = '0;

    int total = 0, bad = 0, cyc = 0;
    logic [31:0] model_ca = '0;

    always #(CLK_P/2) clk = ~clk;

    cfgdec_top u_dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n)
        chk(!(cfg_req && pio_req), "R11 channels exclusive", {cfg_req, pio_req}, 0);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // one host access; the bench plays the downstream responder
    task automatic access(input logic we, input logic [13:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input int dly, input logic hit,
                          input logic [31:0] dsd, input string tag);
        int k;
        logic [31:0] exp_rd;
        if (a == A_PORT && be == 4'hF) k = 0;
        else if (a == D_PORT && model_ca[31]) k = 1;
        else k = 2;
        hst_req = 1; hst_we = we; hst_addr = a; hst_be = be; hst_wdata = wd;
        @(negedge clk);
        if (k == 0) begin
            chk(hst_done === 1'b1, {tag, " R10 done next cycle"}, hst_done, 1);
            chk(!cfg_req && !pio_req, {tag, " R10 no downstream"}, {cfg_req, pio_req}, 0);
            if (!we) chk(hst_rdata === model_ca, {tag, " R2 readback"}, hst_rdata, model_ca);
            else model_ca = wd & KEEP;
        end else begin
            chk(hst_done === 1'b0, {tag, " R7 stall"}, hst_done, 0);
            if (k == 1) begin
                chk(cfg_req && !pio_req, {tag, " R4 cfg_req"}, {cfg_req, pio_req}, 2);
                chk({cfg_bus, cfg_dev, cfg_fn, cfg_idx} === {model_ca[23:16], model_ca[15:11], model_ca[10:8], model_ca[7:2]},
                    {tag, " R4 target"}, {8'h0, cfg_bus, cfg_dev, cfg_fn, cfg_idx},
                    {8'h0, model_ca[23:2]});
                chk(cfg_we === we && cfg_be === be && cfg_wdata === wd, {tag, " R5 we/be/data"},
                    cfg_wdata, wd);
            end else begin
                chk(pio_req && !cfg_req, {tag, " R9 pio_req"}, {cfg_req, pio_req}, 1);
                chk(pio_addr === a && pio_be === be && pio_we === we && pio_wdata === wd,
                    {tag, " R9 pio fields"}, {18'h0, pio_addr}, {18'h0, a});
            end
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk(hst_done === 1'b0 && (k == 1 ? cfg_req : pio_req), {tag, " R7 wait"}, hst_done, 0);
            end
            if (k == 1) begin cfg_rsp_valid = 1; cfg_rsp_hit = hit; cfg_rsp_data = dsd; end
            else begin pio_done = 1; pio_rdata = dsd; end
            @(negedge clk);
            cfg_rsp_valid = 0; pio_done = 0;
            chk(hst_done === 1'b1, {tag, " R7 done after response"}, hst_done, 1);
            exp_rd = (k == 1 && !hit) ? 32'hFFFF_FFFF : dsd;
            if (!we) chk(hst_rdata === exp_rd, {tag, " R7/R8 read data"}, hst_rdata, exp_rd);
        end
        hst_req = 0;
        @(negedge clk);
        chk(hst_done === 1'b0 && !cfg_req && !pio_req, {tag, " R11 single pulse"}, hst_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(hst_done === 0 && cfg_req === 0 && pio_req === 0, "R1 reset outputs", {hst_done, cfg_req, pio_req}, 0);
        rst_n = 1;
        @(negedge clk);
        access(0, A_PORT, 4'hF, 0, 0, 0, 0, "R1 reset read");
        access(1, A_PORT, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, "R2 all ones write");
        access(0, A_PORT, 4'hF, 0, 0, 0, 0, "R2 masked read");
        access(1, A_PORT, 4'hF, 32'h8012_3A5C, 0, 0, 0, "R2 write");
        access(0, A_PORT, 4'hF, 0, 0, 0, 0, "R2 read");
        access(1, A_PORT, 4'h3, 32'h0000_0000, 1, 0, 0, "R3 partial write");
        access(0, A_PORT, 4'hF, 0, 0, 0, 0, "R3 latch unchanged");
        access(0, A_PORT, 4'hC, 0, 2, 0, 32'h1357_9BDF, "R3 partial read");
        access(0, D_PORT, 4'hF, 0, 3, 1, 32'hDEAD_BEEF, "R4 cfg read");
        access(1, D_PORT, 4'b0100, 32'h00AB_0000, 0, 1, 0, "R5 cfg byte write");
        access(0, D_PORT, 4'b0011, 0, 2, 0, 32'h1234_5678, "R8 cfg miss");
        access(1, A_PORT, 4'hF, 32'h0012_3A5C, 0, 0, 0, "R6 disable");
        access(0, D_PORT, 4'hF, 0, 1, 1, 32'hCAFE_0001, "R6 data port disabled");
        access(1, 14'h0020, 4'h1, 32'h0000_00A5, 0, 0, 0, "R9 other write");
        access(0, 14'h0021, 4'hF, 0, 4, 0, 32'h0BAD_F00D, "R9 other read");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule